// File: doc/BRIEF.md
# Dual-Port Mailbox Interrupt Controller

This block sits next to a two-ported byte memory with a 14-bit address on each side and gives the two sides a doorbell. The two highest addresses serve as mailboxes: one addressed to the left side, one to the right. When one side writes the other side's mailbox, the receiving side's active-low interrupt output falls. That interrupt stays asserted until the receiving side reads its own mailbox. The message byte itself lives in the memory array. This block watches the access controls of both sides and keeps only the two interrupt flags.

A global enable turns the feature on. While it is low, no flag can be set and both flags are held inactive, so the two top addresses behave as plain storage. The flags are registered. Each one changes on the rising clock edge that follows the access causing the change.

Top module: `mbox_irq_ctrl`

## Requirements
- R1: After reset, both `lt_irq_n` and `rt_irq_n` are high.
- R2: With `irq_en` high, a right-side write to address 0x3FFE drives `lt_irq_n` low after the next rising edge.
- R3: With `irq_en` high, a left-side write to address 0x3FFF drives `rt_irq_n` low after the next rising edge.
- R4: A side performs a write only when its chip select and its write-enable are both low. A write-enable without chip select does not set a flag, and neither does a chip select with write-enable high.
- R5: A side clears its own flag on the next edge by accessing its own mailbox with chip select and output enable both low. The left mailbox is 0x3FFE and the right mailbox is 0x3FFF. The write-enable level does not matter for this clear.
- R6: An access with output enable high does not clear a flag, and neither does an access with chip select high or an access to the other mailbox address.
- R7: A write by one side to its own mailbox does not set its own flag. A write to any address other than the two mailboxes sets no flag.
- R8: When a set and a clear of the same flag occur in the same cycle, the flag ends up active.
- R9: While `irq_en` is low, both flags go inactive at the next edge, and writes to the mailboxes set nothing.
- R10: A flag keeps its value in cycles with no set, no clear, and `irq_en` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_en | input | 1 | Enables the mailbox interrupt feature |
| lt_cs_n | input | 1 | Left chip select, active low |
| lt_oe_n | input | 1 | Left output enable, active low |
| lt_we_n | input | 1 | Left write-enable, active low |
| lt_addr | input | 14 | Left address |
| rt_cs_n | input | 1 | Right chip select, active low |
| rt_oe_n | input | 1 | Right output enable, active low |
| rt_we_n | input | 1 | Right write-enable, active low |
| rt_addr | input | 14 | Right address |
| lt_irq_n | output | 1 | Interrupt to the left side, active low |
| rt_irq_n | output | 1 | Interrupt to the right side, active low |

## Verification
The main function is exercised with cross-side writes to each mailbox and with owner reads that use either write-enable level. It is also driven with near misses: a missing chip select, output enable held high, a neighbouring address, the wrong mailbox, and a write by a side to its own mailbox. Each near miss must leave the flag unchanged, which distinguishes the full access decode from a decode that looks only at the address or at a single strobe. A cycle in which both sides hit the same mailbox at once confirms that the set takes priority. Toggling the enable with flags pending, and writing while it is low, confirms that the force-inactive path works.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

  typedef struct packed {
    logic cs_n;
    logic oe_n;
    logic we_n;
  } port_ctl_t;

  function automatic logic ctl_is_write(port_ctl_t c);
    return (c.cs_n == 1'b0) && (c.we_n == 1'b0);
  endfunction

  function automatic logic ctl_is_fetch(port_ctl_t c);
    return (c.cs_n == 1'b0) && (c.oe_n == 1'b0);
  endfunction

  // mailbox index 0 sits one below the top address, index 1 at the top
  function automatic int unsigned box_address(int unsigned aw, int unsigned idx);
    return (32'd1 << aw) - 32'd2 + idx;
  endfunction

endpackage

// File: rtl/mbx_decode.sv
module mbx_decode
  import mbx_pkg::*;
#(
  parameter int unsigned ADDR_W = 14,
  parameter int unsigned N_BOX  = 2
) (
  input  port_ctl_t         ctl,
  input  logic [ADDR_W-1:0] addr,
  output logic [N_BOX-1:0]  wr_box,
  output logic [N_BOX-1:0]  rd_box
);

  logic is_wr;
  logic is_rd;

  assign is_wr = ctl_is_write(ctl);
  assign is_rd = ctl_is_fetch(ctl);

  for (genvar g = 0; g < N_BOX; g++) begin : g_box
    localparam logic [ADDR_W-1:0] BOX_A = ADDR_W'(box_address(ADDR_W, g));
    logic hit;
    assign hit       = (addr == BOX_A);
    assign wr_box[g] = hit && is_wr;
    assign rd_box[g] = hit && is_rd;
  end

endmodule

// File: rtl/mbx_flag.sv
module mbx_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic set_ev,
  input  logic clr_ev,
  output logic active
);

  logic nxt;

  always_comb begin
    nxt = active;
    if (!en)         nxt = 1'b0;
    else if (set_ev) nxt = 1'b1;
    else if (clr_ev) nxt = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) active <= 1'b0;
    else        active <= nxt;
  end

  assert_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (en && set_ev) |=> active);

  assert_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (en && clr_ev && !set_ev) |=> !active);

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !set_ev && !clr_ev) |=> $stable(active));

  assert_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!en) |=> !active);

endmodule

// File: rtl/mbox_irq_ctrl.sv
module mbox_irq_ctrl
  import mbx_pkg::*;
#(
  parameter int unsigned ADDR_W = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              irq_en,
  input  logic              lt_cs_n,
  input  logic              lt_oe_n,
  input  logic              lt_we_n,
  input  logic [ADDR_W-1:0] lt_addr,
  input  logic              rt_cs_n,
  input  logic              rt_oe_n,
  input  logic              rt_we_n,
  input  logic [ADDR_W-1:0] rt_addr,
  output logic              lt_irq_n,
  output logic              rt_irq_n
);

  localparam int unsigned N_BOX = 2;
  localparam int unsigned BOX_LT = 0;
  localparam int unsigned BOX_RT = 1;

  port_ctl_t lt_ctl, rt_ctl;
  logic [N_BOX-1:0] lt_wr, lt_rd, rt_wr, rt_rd;
  logic lt_act, rt_act;

  // named events, visible to assertions
  logic lt_set_ev, lt_clr_ev, rt_set_ev, rt_clr_ev;

  assign lt_ctl = '{cs_n: lt_cs_n, oe_n: lt_oe_n, we_n: lt_we_n};
  assign rt_ctl = '{cs_n: rt_cs_n, oe_n: rt_oe_n, we_n: rt_we_n};

  mbx_decode #(.ADDR_W(ADDR_W), .N_BOX(N_BOX)) u_dec_lt (
    .ctl(lt_ctl), .addr(lt_addr), .wr_box(lt_wr), .rd_box(lt_rd));

  mbx_decode #(.ADDR_W(ADDR_W), .N_BOX(N_BOX)) u_dec_rt (
    .ctl(rt_ctl), .addr(rt_addr), .wr_box(rt_wr), .rd_box(rt_rd));

  assign lt_set_ev = rt_wr[BOX_LT];
  assign lt_clr_ev = lt_rd[BOX_LT];
  assign rt_set_ev = lt_wr[BOX_RT];
  assign rt_clr_ev = rt_rd[BOX_RT];

  mbx_flag u_flag_lt (
    .clk(clk), .rst_n(rst_n), .en(irq_en),
    .set_ev(lt_set_ev), .clr_ev(lt_clr_ev), .active(lt_act));

  mbx_flag u_flag_rt (
    .clk(clk), .rst_n(rst_n), .en(irq_en),
    .set_ev(rt_set_ev), .clr_ev(rt_clr_ev), .active(rt_act));

  assign lt_irq_n = ~lt_act;
  assign rt_irq_n = ~rt_act;

  assert_reset_R1: assert property (@(posedge clk)
    (!rst_n) |=> (lt_irq_n && rt_irq_n));

  assert_own_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_en && lt_irq_n && !lt_set_ev && !lt_cs_n && !lt_we_n) |=> lt_irq_n);

  assert_cross_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_en && !lt_cs_n && !lt_we_n && lt_addr == ADDR_W'(box_address(ADDR_W, BOX_RT)))
      |=> !rt_irq_n);

endmodule

// File: tb/sim_mbox_irq_ctrl.sv
module sim_mbox_irq_ctrl;

  localparam logic [13:0] A_LT = 14'h3FFE;
  localparam logic [13:0] A_RT = 14'h3FFF;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic irq_en = 1'b1;
  logic lcs = 1'b1, loe = 1'b1, lwe = 1'b1;
  logic rcs = 1'b1, roe = 1'b1, rwe = 1'b1;
  logic [13:0] la = '0, ra = '0;
  logic lirq, rirq;

  int checks = 0;
  int errors = 0;
  string cur = "R1";
  bit m_lt = 1'b1;
  bit m_rt = 1'b1;

  always #10 clk = ~clk;

  mbox_irq_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .irq_en(irq_en),
    .lt_cs_n(lcs), .lt_oe_n(loe), .lt_we_n(lwe), .lt_addr(la),
    .rt_cs_n(rcs), .rt_oe_n(roe), .rt_we_n(rwe), .rt_addr(ra),
    .lt_irq_n(lirq), .rt_irq_n(rirq));

  // behavioural reference: 1 = inactive
  always @(posedge clk) begin
    bit lw, rw, lr, rr;
    lw = !lcs && !lwe;
    rw = !rcs && !rwe;
    lr = !lcs && !loe;
    rr = !rcs && !roe;
    if (!rst_n || !irq_en) begin
      m_lt <= 1'b1;
      m_rt <= 1'b1;
    end else begin
      if (rw && ra == A_LT)      m_lt <= 1'b0;
      else if (lr && la == A_LT) m_lt <= 1'b1;
      if (lw && la == A_RT)      m_rt <= 1'b0;
      else if (rr && ra == A_RT) m_rt <= 1'b1;
    end
  end

  task automatic pt(string tag, logic got, logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b", tag, got, exp);
    end
  endtask

  task automatic cyc(string tag, bit en,
                     bit c1, bit o1, bit w1, logic [13:0] a1,
                     bit c2, bit o2, bit w2, logic [13:0] a2);
    @(negedge clk);
    pt({cur, " lt"}, lirq, m_lt);
    pt({cur, " rt"}, rirq, m_rt);
    cur = tag;
    irq_en = en;
    lcs = c1; loe = o1; lwe = w1; la = a1;
    rcs = c2; roe = o2; rwe = w2; ra = a2;
  endtask

  task automatic idle(string tag);
    cyc(tag, irq_en, 1, 1, 1, 14'h0, 1, 1, 1, 14'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle("R1");
    pt("R1 lt", lirq, 1'b1);
    pt("R1 rt", rirq, 1'b1);
    // R2 right writes left mailbox
    cyc("R2", 1, 1,1,1,14'h0, 0,1,0,A_LT);
    idle("R10");
    pt("R2 lt", lirq, 1'b0);
    idle("R10"); idle("R10");
    pt("R10 lt", lirq, 1'b0);
    // R6 near-miss clears
    cyc("R6", 1, 0,1,1,A_LT, 1,1,1,14'h0);
    cyc("R6", 1, 1,0,1,A_LT, 1,1,1,14'h0);
    cyc("R6", 1, 0,0,1,A_RT, 1,1,1,14'h0);
    idle("R6");
    pt("R6 lt", lirq, 1'b0);
    // R5 owner read clears
    cyc("R5", 1, 0,0,1,A_LT, 1,1,1,14'h0);
    idle("R5");
    pt("R5 lt", lirq, 1'b1);
    // R3 left writes right mailbox
    cyc("R3", 1, 0,1,0,A_RT, 1,1,1,14'h0);
    idle("R3");
    pt("R3 rt", rirq, 1'b0);
    // R5 clear with write-enable low
    cyc("R5", 1, 1,1,1,14'h0, 0,0,0,A_RT);
    idle("R5");
    pt("R5 rt", rirq, 1'b1);
    // R4 partial strobes
    cyc("R4", 1, 1,1,1,14'h0, 1,1,0,A_LT);
    cyc("R4", 1, 1,1,1,14'h0, 0,0,1,A_LT);
    cyc("R4", 1, 1,1,0,A_RT, 1,1,1,14'h0);
    idle("R4");
    pt("R4 lt", lirq, 1'b1);
    pt("R4 rt", rirq, 1'b1);
    // R7 own mailbox and other addresses
    cyc("R7", 1, 0,1,0,A_LT, 0,1,0,A_RT);
    cyc("R7", 1, 0,1,0,14'h3FFD, 0,1,0,14'h1FFE);
    idle("R7");
    pt("R7 lt", lirq, 1'b1);
    pt("R7 rt", rirq, 1'b1);
    // R8 simultaneous set and clear
    cyc("R8", 1, 0,0,1,A_LT, 0,1,0,A_LT);
    idle("R8");
    pt("R8 lt", lirq, 1'b0);
    cyc("R8", 1, 0,1,0,A_RT, 0,0,1,A_RT);
    idle("R8");
    pt("R8 rt", rirq, 1'b0);
    // R9 disable
    cyc("R9", 0, 1,1,1,14'h0, 1,1,1,14'h0);
    idle("R9");
    pt("R9 lt", lirq, 1'b1);
    pt("R9 rt", rirq, 1'b1);
    cyc("R9", 0, 0,1,0,A_RT, 0,1,0,A_LT);
    idle("R9");
    pt("R9 lt", lirq, 1'b1);
    pt("R9 rt", rirq, 1'b1);
    cyc("R2", 1, 1,1,1,14'h0, 0,1,0,A_LT);
    idle("R2");
    idle("R2");
    pt("R2 lt", lirq, 1'b0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule